// File: doc/BRIEF.md
# Clearable Word Store with Split Data Paths

This block is a synchronous 1024-word by 4-bit memory with one input data bus and one output data bus, so no bidirectional path is needed. Four active-low controls steer it: a select, a write strobe, an output enable and a bulk-clear request. Every command is sampled on the rising clock edge. Read data appears on the output after that same edge, together with a flag that says whether the output is driven. The output bus itself is tri-stated whenever that flag is low.

The bulk clear zeroes the entire array within two cycles. It only acts on a selected device, so a single clear line can be shared by many instances and only the selected ones are wiped. Internally each word has a valid flag. The first clear edge drops the flags of even words and the following edge drops the flags of odd words. Any word whose flag is down reads as zero. Reads made in the cycle between the two edges already mask the odd half. A synchronous active-high system reset drops every flag at once.

Top module: `clrram_top`

## Requirements
- R1: With select low, write strobe low and clear high at an edge, the input data is stored at the addressed word. A later read of that word returns it.
- R2: With select low, output enable low, write strobe high and clear high at an edge, the addressed word appears on `dout` after that edge and `dout_en` is 1.
- R3: After an edge where select is high, output enable is high, write strobe is low or clear is low, `dout_en` is 0 and `dout` is high-impedance.
- R4: A clear request while select is high changes nothing. Previously written words read back unchanged.
- R5: After an edge where select and clear are both low, every word reads 0. This includes a read in the very next cycle, for both even and odd addresses.
- R6: A clear lasting a single edge still completes. Words of both parities read 0 two and more cycles later.
- R7: When clear and write strobe are both low on a selected device, the clear wins and the write data is discarded.
- R8: A write in the cycle right after a clear edge is kept, even at an odd address whose flag is dropped on that same edge.
- R9: While `rst` is high, `dout_en` is 0. After `rst`, every word reads 0.
- R10: The 10-bit address reaches all 1024 words. Address 0, address 1023 and mid-range words hold independent values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all commands sampled on the rising edge |
| rst | input | 1 | Synchronous active-high system reset |
| sel_n | input | 1 | Active-low device select |
| wr_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable |
| clr_n | input | 1 | Active-low bulk-clear request |
| addr | input | 10 | Word address |
| din | input | 4 | Write data |
| dout | output | 4 | Read data; high-impedance when not driven |
| dout_en | output | 1 | High while `dout` carries read data |

## Verification
The bound checker watches, on every cycle, that the drive flag follows the read decode of the previous edge. It also checks that a read right after a write to the same address returns the written data, and that reads one or two cycles after a clear return zero. On every cycle it further checks that an unselected device keeps its valid flags, that a write made during the second clear edge keeps its flag, and that reset empties everything. The priority of clear over a simultaneous write, an unselected clear leaving stored data intact, and the independence of the lowest, highest and middle words can only be shown by the bench's scenarios. Each of these needs a write, a disturbance and a later readback of real data.

// File: rtl/clrram_pkg.sv
package clrram_pkg;

    // Command decoded from the four active-low controls at a clock edge.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_CLEAR = 2'd3
    } op_e;

    // Flag-dropping actions for the current edge.
    typedef struct packed {
        logic wipe_even;  // drop flags of even words at this edge
        logic wipe_odd;   // drop flags of odd words at this edge
        logic busy;       // odd half still awaiting its wipe
    } phase_s;

    // Clear outranks write; read needs the write strobe released.
    function automatic op_e decode_op(input logic sel_n, input logic wr_n,
                                      input logic oe_n, input logic clr_n);
        op_e r;
        r = OP_IDLE;
        if (!sel_n) begin
            if (!clr_n)
                r = OP_CLEAR;
            else if (!wr_n)
                r = OP_WRITE;
            else if (!oe_n)
                r = OP_READ;
        end
        return r;
    endfunction

    // A word is held back when its flag is down or its half is pending.
    function automatic logic word_live(input logic flag, input logic odd,
                                       input logic busy);
        return flag && !(busy && odd);
    endfunction

endpackage

// File: rtl/clrram_ctrl.sv
module clrram_ctrl
    import clrram_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sel_n,
    input  logic   wr_n,
    input  logic   oe_n,
    input  logic   clr_n,
    output op_e    op,
    output phase_s ph
);

    logic pend_q;

    assign op = decode_op(sel_n, wr_n, oe_n, clr_n);

    // Second half of the wipe is owed on the edge after any clear edge.
    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else
            pend_q <= (op == OP_CLEAR);
    end

    always_comb begin
        ph.wipe_even = (op == OP_CLEAR);
        ph.wipe_odd  = pend_q;
        ph.busy      = pend_q;
    end

endmodule

// File: rtl/clrram_flags.sv
module clrram_flags #(
    parameter int ADDR_W = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_go,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic                 wipe_even,
    input  logic                 wipe_odd,
    output logic [(1<<ADDR_W)-1:0] flags
);

    localparam int WORDS = 1 << ADDR_W;

    // One flag per word; a write sets it and outranks the wipe on the same edge.
    for (genvar i = 0; i < WORDS; i++) begin : g_flag
        localparam logic ODD = (i % 2) == 1;
        logic hit;
        logic wipe;
        assign hit  = wr_go && (wr_addr == ADDR_W'(i));
        assign wipe = ODD ? wipe_odd : wipe_even;
        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= 1'b0;
            else if (hit)
                flags[i] <= 1'b1;
            else if (wipe)
                flags[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/clrram_array.sv
module clrram_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              wr_go,
    input  logic              rd_go,
    input  logic              rd_live,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);

    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (wr_go)
            mem[addr] <= din;
    end

    // Registered read; a dead word yields zero instead of stale data.
    always_ff @(posedge clk) begin
        if (rd_go)
            q <= rd_live ? mem[addr] : '0;
    end

endmodule

// File: rtl/clrram_top.sv
module clrram_top
    import clrram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              oe_n,
    input  logic              clr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    localparam int WORDS = 1 << ADDR_W;

    op_e               op;
    phase_s            ph;
    logic              wr_go;
    logic              rd_go;
    logic              rd_live;
    logic [WORDS-1:0]  flags;
    logic [DATA_W-1:0] q;
    logic              en_q;

    clrram_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .sel_n (sel_n),
        .wr_n  (wr_n),
        .oe_n  (oe_n),
        .clr_n (clr_n),
        .op    (op),
        .ph    (ph)
    );

    assign wr_go = (op == OP_WRITE);
    assign rd_go = (op == OP_READ);

    clrram_flags #(.ADDR_W(ADDR_W)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .wr_go     (wr_go),
        .wr_addr   (addr),
        .wipe_even (ph.wipe_even),
        .wipe_odd  (ph.wipe_odd),
        .flags     (flags)
    );

    assign rd_live = word_live(flags[addr], addr[0], ph.busy);

    clrram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .wr_go   (wr_go),
        .rd_go   (rd_go),
        .rd_live (rd_live),
        .addr    (addr),
        .din     (din),
        .q       (q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else
            en_q <= rd_go;
    end

    assign dout_en = en_q;
    assign dout    = en_q ? q : {DATA_W{1'bz}};

endmodule

// File: rtl/clrram_chk.sv
module clrram_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  sel_n,
    input logic                  wr_n,
    input logic                  oe_n,
    input logic                  clr_n,
    input logic [ADDR_W-1:0]     addr,
    input logic [DATA_W-1:0]     din,
    input logic [DATA_W-1:0]     dout,
    input logic                  dout_en,
    input logic                  pend,
    input logic [(1<<ADDR_W)-1:0] flags
);

    logic rd_c, wr_c, clr_c;
    assign clr_c = !sel_n && !clr_n;
    assign wr_c  = !sel_n && !wr_n && clr_n;
    assign rd_c  = !sel_n && wr_n && !oe_n && clr_n;

    assert_rd_drive_R2: assert property (@(posedge clk) disable iff (rst)
        rd_c |=> dout_en);

    assert_float_R3: assert property (@(posedge clk) disable iff (rst)
        !rd_c |=> !dout_en);

    assert_write_read_R1: assert property (@(posedge clk) disable iff (rst)
        (rd_c && $past(wr_c) && !$past(rst) && addr == $past(addr))
        |=> dout == $past(din, 2));

    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_c && $past(clr_c)) |=> dout == '0);

    assert_clear_done_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_c && $past(clr_c, 2) && !$past(clr_c) && !$past(wr_c))
        |=> dout == '0);

    assert_unsel_keep_R4: assert property (@(posedge clk) disable iff (rst)
        (sel_n && !pend) |=> $stable(flags));

    assert_late_write_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_c && pend) |=> flags[$past(addr)]);

    assert_reset_empty_R9: assert property (@(posedge clk)
        rst |=> (!dout_en && flags == '0));

endmodule

bind clrram_top clrram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sel_n   (sel_n),
    .wr_n    (wr_n),
    .oe_n    (oe_n),
    .clr_n   (clr_n),
    .addr    (addr),
    .din     (din),
    .dout    (dout),
    .dout_en (dout_en),
    .pend    (ph.busy),
    .flags   (flags)
);

// File: tb/tb_clrram_top.sv
`timescale 1ns/1ps
module tb_clrram_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       oe_n = 1'b1;
    logic       clr_n = 1'b1;
    logic [9:0] addr = '0;
    logic [3:0] din = '0;
    wire  [3:0] dout;
    wire        dout_en;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    clrram_top dut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n), .oe_n(oe_n),
        .clr_n(clr_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Drive one command at a falling edge, then wait past the next rising edge.
    task automatic step(input logic s, input logic w, input logic o,
                        input logic c, input logic [9:0] a, input logic [3:0] d);
        sel_n = s; wr_n = w; oe_n = o; clr_n = c; addr = a; din = d;
        @(negedge clk);
    endtask

    task automatic idle();
        step(1, 1, 1, 1, '0, '0);
    endtask

    task automatic wr(input logic [9:0] a, input logic [3:0] d);
        step(0, 0, 1, 1, a, d);
    endtask

    task automatic rd_check(input logic [9:0] a, input logic [3:0] exp, input string req);
        step(0, 1, 0, 1, a, '0);
        check(dout_en === 1'b1, req, int'(dout_en), 1);
        check(dout_en === 1'b1 && dout === exp, req, int'(dout), int'(exp));
    endtask

    task automatic t_reset();
        check(dout_en === 1'b0, "R9 dout_en in reset", int'(dout_en), 0);
        rst = 1'b0;
        idle();
        rd_check(10'd5, 4'h0, "R9 word 5 after reset");
        rd_check(10'd1023, 4'h0, "R9 word 1023 after reset");
    endtask

    task automatic t_rw();
        wr(10'd0, 4'hA);
        wr(10'd1023, 4'h5);
        wr(10'd1, 4'h3);
        wr(10'd512, 4'hC);
        rd_check(10'd0, 4'hA, "R10 word 0");
        rd_check(10'd1023, 4'h5, "R10 word 1023");
        rd_check(10'd1, 4'h3, "R1 word 1");
        rd_check(10'd512, 4'hC, "R2 word 512");
        wr(10'd1, 4'h9);
        rd_check(10'd1, 4'h9, "R1 overwrite word 1");
    endtask

    task automatic t_float();
        step(0, 1, 1, 1, 10'd0, '0);
        check(dout_en === 1'b0, "R3 oe high", int'(dout_en), 0);
        step(1, 1, 0, 1, 10'd0, '0);
        check(dout_en === 1'b0, "R3 unselected", int'(dout_en), 0);
        step(0, 0, 0, 1, 10'd700, 4'h6);
        check(dout_en === 1'b0, "R3 write cycle", int'(dout_en), 0);
        rd_check(10'd700, 4'h6, "R1 write with oe low");
    endtask

    task automatic t_unsel_clear();
        step(1, 1, 1, 0, 10'd0, '0);
        check(dout_en === 1'b0, "R3 unselected clear", int'(dout_en), 0);
        step(1, 1, 1, 0, 10'd0, '0);
        idle();
        rd_check(10'd0, 4'hA, "R4 word 0 kept");
        rd_check(10'd1, 4'h9, "R4 word 1 kept");
        rd_check(10'd1023, 4'h5, "R4 word 1023 kept");
    endtask

    task automatic t_clear_fast();
        step(0, 1, 0, 0, 10'd0, '0);
        check(dout_en === 1'b0, "R3 clear cycle", int'(dout_en), 0);
        rd_check(10'd1, 4'h0, "R5 odd word next cycle");
        rd_check(10'd1023, 4'h0, "R6 odd word 1023");
        rd_check(10'd0, 4'h0, "R6 even word 0");
        rd_check(10'd512, 4'h0, "R6 even word 512");
        rd_check(10'd700, 4'h0, "R6 even word 700");
    endtask

    task automatic t_clear_next_even();
        wr(10'd8, 4'hE);
        step(0, 1, 1, 0, 10'd0, '0);
        rd_check(10'd8, 4'h0, "R5 even word next cycle");
    endtask

    task automatic t_priority();
        wr(10'd10, 4'h7);
        step(0, 0, 1, 0, 10'd10, 4'hF);
        idle();
        rd_check(10'd10, 4'h0, "R7 write during clear discarded");
    endtask

    task automatic t_late_write();
        wr(10'd3, 4'h9);
        wr(10'd4, 4'h8);
        step(0, 1, 1, 0, 10'd0, '0);
        wr(10'd3, 4'h6);
        idle();
        rd_check(10'd3, 4'h6, "R8 odd write after clear edge");
        rd_check(10'd4, 4'h0, "R8 neighbour still cleared");
    endtask

    task automatic t_clear_held();
        wr(10'd20, 4'h2);
        wr(10'd21, 4'hD);
        repeat (3) step(0, 1, 1, 0, 10'd0, '0);
        rd_check(10'd21, 4'h0, "R5 held clear odd");
        rd_check(10'd20, 4'h0, "R5 held clear even");
    endtask

    task automatic t_reset_mid();
        wr(10'd33, 4'hB);
        rd_check(10'd33, 4'hB, "R1 before reset");
        rst = 1'b1;
        idle();
        check(dout_en === 1'b0, "R9 dout_en during reset", int'(dout_en), 0);
        rst = 1'b0;
        rd_check(10'd33, 4'h0, "R9 word after reset");
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        t_rw();
        t_float();
        t_unsel_clear();
        t_clear_fast();
        t_clear_next_even();
        t_priority();
        t_late_write();
        t_clear_held();
        t_reset_mid();
        idle();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog all requirements act=%0d exp=%0d", 0, 1);
        finish_run();
    end

endmodule